// File: doc/BRIEF.md
# PCM Codec Clock and Mode Controller

This block is the supervisory logic of a telephony PCM codec. It runs on a fast free-running system clock and watches five slow codec pins: the transmit master clock, the receive master clock (which doubles as a power-down strap when held high), the receive bit clock (which doubles as a clock-frequency select when held static), and the transmit and receive frame syncs. Every pin passes through a two-flop synchroniser. A per-pin monitor then decides whether the pin is toggling or sitting at a static level.

From that activity picture the block settles the codec's operating mode: full duplex, transmit-only half channel, receive-only half channel, or power-down. It also selects the internal master clock and the receive bit clock, and reports which master clock frequency the converter timing must assume for the chosen companding law. It produces the enables that the serial and analog sections consume.

When both frame syncs stop, power-down follows after a programmable idle time. A static-high receive master clock pin forces power-down at once. After any power-down, the transmit output stays disabled until the second transmit frame sync rising edge seen after wake-up.

Top module: `pcm_mode_ctrl`

## Requirements
- R1: While reset is high and after its release with all pins static low, mode_o is 00 (power-down), tx_oe_o is 0 and gsx_en_o is 0.
- R2: A pin counts as toggling from the third system clock after one of its edges is sampled until ACT_WIN clocks pass with no further edge; otherwise it counts as static at its synchronised level.
- R3: mode_o encodes 01 full duplex when both frame syncs toggle, 10 transmit half channel when only the transmit frame sync toggles, 11 receive half channel when only the receive frame sync toggles, and 00 power-down.
- R4: mclk_src_rx_o is 1 (receive master clock) only in receive half-channel mode with the receive master clock toggling; otherwise it is 0 (transmit master clock).
- R5: rx_bclk_src_rx_o is 1 when the receive bit clock pin toggles and 0 when it is static, in which case the transmit bit clock serves both directions.
- R6: The select reads as 1 when the receive bit clock pin toggles or is static high. freq_code_o is 10 (2.048 MHz) for alaw_i=0 with the select 0, or for alaw_i=1 with the select 1. It is 01 (1.536/1.544 MHz) in the other two cases.
- R7: With both frame syncs static and no other forcing, the previous mode is kept for PD_CYCLES idle clocks, then mode_o becomes 00.
- R8: When the receive master clock pin is static high, mode_o is 00 whatever the frame syncs do. Leaving power-down requires that pin low or toggling and at least one frame sync toggling.
- R9: In power-down, tx_oe_o and gsx_en_o are 0, rx_gnd_o is 1 and rx_data_en_o is 0.
- R10: In transmit half channel, rx_gnd_o is 1 and rx_data_en_o is 0. In receive half channel, tx_oe_o is 0 while gsx_en_o stays 1.
- R11: After mode_o leaves 00, tx_oe_o stays 0 until the second transmit frame sync rising edge has been seen. It is asserted only in full duplex or transmit half channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_tx_i | input | 1 | Transmit master clock pin |
| mclk_rx_pdn_i | input | 1 | Receive master clock pin, power-down strap when static high |
| bclk_rx_sel_i | input | 1 | Receive bit clock pin, frequency select when static |
| fs_tx_i | input | 1 | Transmit frame sync pin |
| fs_rx_i | input | 1 | Receive frame sync pin |
| alaw_i | input | 1 | Companding law: 0 mu-law, 1 A-law |
| mode_o | output | 2 | Operating mode code (R3) |
| mclk_src_rx_o | output | 1 | Internal master clock from receive pin |
| rx_bclk_src_rx_o | output | 1 | Receive bit clock from receive pin |
| freq_code_o | output | 2 | Expected master clock frequency code (R6) |
| tx_oe_o | output | 1 | Transmit data and time-slot output-enable qualifier |
| gsx_en_o | output | 1 | Transmit input amplifier enable |
| rx_gnd_o | output | 1 | Receive analog output held at analog ground |
| rx_data_en_o | output | 1 | Receive PCM data accepted |

## Verification
Two functions can act in the same cycle. One is forced power-down from the strap pin. The other is the transmit re-enable counter, which is fed by frame sync edges. The bench provokes the overlap by keeping the transmit frame sync running while the strap pin rises and falls, so that sync edges land in the cycles where power-down is entered and left. A behavioural per-clock model decides, cycle by cycle, whether each edge belongs to the new power-up epoch, and every output is compared against it on every clock.

// File: rtl/pcm_ctl_pkg.sv
package pcm_ctl_pkg;

    typedef enum logic [1:0] {
        MODE_PDN  = 2'b00,
        MODE_FULL = 2'b01,
        MODE_TXH  = 2'b10,
        MODE_RXH  = 2'b11
    } pcm_mode_e;

    typedef enum logic [1:0] {
        FREQ_NONE = 2'b00,
        FREQ_1536 = 2'b01,
        FREQ_2048 = 2'b10
    } mclk_freq_e;

    localparam int NPIN      = 5;
    localparam int PIN_MCLKX = 0;
    localparam int PIN_MCLKR = 1;
    localparam int PIN_BCLKR = 2;
    localparam int PIN_FSX   = 3;
    localparam int PIN_FSR   = 4;

    typedef struct packed {
        logic act;
        logic lvl;
        logic rise;
    } pin_stat_t;

    function automatic mclk_freq_e freq_lookup(input logic alaw, input logic sel_hi);
        if (alaw)
            return sel_hi ? FREQ_2048 : FREQ_1536;
        return sel_hi ? FREQ_1536 : FREQ_2048;
    endfunction

    function automatic logic tx_mode(input pcm_mode_e m);
        return (m == MODE_FULL) || (m == MODE_TXH);
    endfunction

endpackage

// File: rtl/pcm_pin_monitor.sv
module pcm_pin_monitor
    import pcm_ctl_pkg::*;
#(
    parameter int WIN = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    output pin_stat_t stat_o
);
    localparam int               CW      = $clog2(WIN + 1);
    localparam logic [CW-1:0]    AGE_MAX = CW'(WIN);

    logic          s1, s2, s3;
    logic [CW-1:0] age;
    logic          act;
    logic          chg;

    assign chg = s2 ^ s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            s3  <= 1'b0;
            age <= AGE_MAX;
            act <= 1'b0;
        end else begin
            s1 <= pin_i;
            s2 <= s1;
            s3 <= s2;
            if (chg) begin
                age <= '0;
                act <= 1'b1;
            end else if (age != AGE_MAX) begin
                age <= age + 1'b1;
                if (age == AGE_MAX - 1'b1)
                    act <= 1'b0;
            end
        end
    end

    assign stat_o = '{act: act, lvl: s2, rise: s2 & ~s3};

endmodule

// File: rtl/pcm_mode_fsm.sv
module pcm_mode_fsm
    import pcm_ctl_pkg::*;
#(
    parameter int PD_CYCLES = 100000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fsx_act_i,
    input  logic      fsr_act_i,
    input  logic      pdn_force_i,
    output pcm_mode_e mode_o
);
    localparam int            IW       = $clog2(PD_CYCLES + 1);
    localparam logic [IW-1:0] IDLE_MAX = IW'(PD_CYCLES);
    localparam logic [IW-1:0] IDLE_END = IW'(PD_CYCLES - 1);

    pcm_mode_e     mode_q, mode_n;
    logic [IW-1:0] idle_q, idle_n;
    logic          any_fs;

    assign any_fs = fsx_act_i | fsr_act_i;

    always_comb begin
        if (any_fs)
            idle_n = '0;
        else if (idle_q == IDLE_MAX)
            idle_n = idle_q;
        else
            idle_n = idle_q + 1'b1;
    end

    always_comb begin
        mode_n = mode_q;
        if (pdn_force_i)
            mode_n = MODE_PDN;
        else if (fsx_act_i && fsr_act_i)
            mode_n = MODE_FULL;
        else if (fsx_act_i)
            mode_n = MODE_TXH;
        else if (fsr_act_i)
            mode_n = MODE_RXH;
        else if (idle_q >= IDLE_END)
            mode_n = MODE_PDN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_PDN;
            idle_q <= '0;
        end else begin
            mode_q <= mode_n;
            idle_q <= idle_n;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/pcm_txen_gate.sv
module pcm_txen_gate
    import pcm_ctl_pkg::*;
#(
    parameter int ARM_PULSES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  pcm_mode_e mode_i,
    input  logic      fsx_rise_i,
    output logic      tx_oe_o
);
    localparam int            PW      = $clog2(ARM_PULSES + 1);
    localparam logic [PW-1:0] ARM_CNT = PW'(ARM_PULSES);

    logic [PW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= '0;
        else if (mode_i == MODE_PDN)
            seen_q <= '0;
        else if (fsx_rise_i && seen_q != ARM_CNT)
            seen_q <= seen_q + 1'b1;
    end

    assign tx_oe_o = (seen_q == ARM_CNT) && tx_mode(mode_i);

endmodule

// File: rtl/pcm_mode_ctrl.sv
module pcm_mode_ctrl
    import pcm_ctl_pkg::*;
#(
    parameter int ACT_WIN    = 64,
    parameter int PD_CYCLES  = 100000,
    parameter int ARM_PULSES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mclk_tx_i,
    input  logic       mclk_rx_pdn_i,
    input  logic       bclk_rx_sel_i,
    input  logic       fs_tx_i,
    input  logic       fs_rx_i,
    input  logic       alaw_i,
    output logic [1:0] mode_o,
    output logic       mclk_src_rx_o,
    output logic       rx_bclk_src_rx_o,
    output logic [1:0] freq_code_o,
    output logic       tx_oe_o,
    output logic       gsx_en_o,
    output logic       rx_gnd_o,
    output logic       rx_data_en_o
);
    logic [NPIN-1:0] pins_raw;
    pin_stat_t       stat [NPIN];
    pcm_mode_e       mode;
    logic            pdn_force;
    logic            sel_hi;
    mclk_freq_e      freq;

    assign pins_raw[PIN_MCLKX] = mclk_tx_i;
    assign pins_raw[PIN_MCLKR] = mclk_rx_pdn_i;
    assign pins_raw[PIN_BCLKR] = bclk_rx_sel_i;
    assign pins_raw[PIN_FSX]   = fs_tx_i;
    assign pins_raw[PIN_FSR]   = fs_rx_i;

    for (genvar g = 0; g < NPIN; g++) begin : g_mon
        pcm_pin_monitor #(.WIN(ACT_WIN)) u_mon (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pins_raw[g]),
            .stat_o (stat[g])
        );
    end

    assign pdn_force = ~stat[PIN_MCLKR].act & stat[PIN_MCLKR].lvl;

    pcm_mode_fsm #(.PD_CYCLES(PD_CYCLES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .fsx_act_i   (stat[PIN_FSX].act),
        .fsr_act_i   (stat[PIN_FSR].act),
        .pdn_force_i (pdn_force),
        .mode_o      (mode)
    );

    pcm_txen_gate #(.ARM_PULSES(ARM_PULSES)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .fsx_rise_i (stat[PIN_FSX].rise),
        .tx_oe_o    (tx_oe_o)
    );

    assign sel_hi = stat[PIN_BCLKR].act | stat[PIN_BCLKR].lvl;
    assign freq   = freq_lookup(alaw_i, sel_hi);

    always_comb begin
        gsx_en_o     = 1'b1;
        rx_gnd_o     = 1'b0;
        rx_data_en_o = 1'b0;
        unique case (mode)
            MODE_PDN:  begin gsx_en_o = 1'b0; rx_gnd_o = 1'b1; end
            MODE_TXH:  rx_gnd_o = 1'b1;
            MODE_FULL: rx_data_en_o = 1'b1;
            MODE_RXH:  rx_data_en_o = 1'b1;
            default:   rx_gnd_o = 1'b1;
        endcase
    end

    assign mode_o           = mode;
    assign mclk_src_rx_o    = (mode == MODE_RXH) && stat[PIN_MCLKR].act;
    assign rx_bclk_src_rx_o = stat[PIN_BCLKR].act;
    assign freq_code_o      = freq;

endmodule

// File: rtl/pcm_mode_ctrl_chk.sv
module pcm_mode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_o,
    input logic       mclk_src_rx_o,
    input logic       tx_oe_o,
    input logic       gsx_en_o,
    input logic       rx_gnd_o,
    input logic       rx_data_en_o
);
    a_r9_pdn_outputs: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b00) |-> (!tx_oe_o && !gsx_en_o && rx_gnd_o && !rx_data_en_o));

    a_r4_rx_master_only_rxhalf: assert property (@(posedge clk) disable iff (rst)
        mclk_src_rx_o |-> (mode_o == 2'b11));

    a_r11_oe_in_tx_modes: assert property (@(posedge clk) disable iff (rst)
        tx_oe_o |-> (mode_o == 2'b01 || mode_o == 2'b10));

    a_r11_no_oe_at_wakeup: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) == 2'b00 && mode_o != 2'b00) |-> !tx_oe_o);

    a_r10_txhalf_rx_grounded: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10) |-> (rx_gnd_o && !rx_data_en_o));

    a_r10_rxhalf_tx_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b11) |-> (!tx_oe_o && gsx_en_o));
endmodule

bind pcm_mode_ctrl pcm_mode_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_o        (mode_o),
    .mclk_src_rx_o (mclk_src_rx_o),
    .tx_oe_o       (tx_oe_o),
    .gsx_en_o      (gsx_en_o),
    .rx_gnd_o      (rx_gnd_o),
    .rx_data_en_o  (rx_data_en_o)
);

// File: tb/tb_pcm_mode_ctrl.sv
module tb_pcm_mode_ctrl;
    localparam int WIN = 8;
    localparam int PD  = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alaw = 1'b0;
    bit   pin_v [5];
    int   half  [5];
    int   cyc = 0;

    logic [1:0] mode_o, freq_code_o;
    logic mclk_src_rx_o, rx_bclk_src_rx_o, tx_oe_o, gsx_en_o, rx_gnd_o, rx_data_en_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pcm_mode_ctrl #(.ACT_WIN(WIN), .PD_CYCLES(PD), .ARM_PULSES(2)) dut (
        .clk(clk), .rst(rst),
        .mclk_tx_i(pin_v[0]), .mclk_rx_pdn_i(pin_v[1]), .bclk_rx_sel_i(pin_v[2]),
        .fs_tx_i(pin_v[3]), .fs_rx_i(pin_v[4]), .alaw_i(alaw),
        .mode_o(mode_o), .mclk_src_rx_o(mclk_src_rx_o), .rx_bclk_src_rx_o(rx_bclk_src_rx_o),
        .freq_code_o(freq_code_o), .tx_oe_o(tx_oe_o), .gsx_en_o(gsx_en_o),
        .rx_gnd_o(rx_gnd_o), .rx_data_en_o(rx_data_en_o)
    );

    // behavioural reference: sample history per pin, age since last sampled edge
    bit q1 [5], q2 [5], q3 [5];
    int age [5];
    int m_mode = 0, m_idle = 0, m_cnt = 0;

    function automatic bit mact(int p);
        return age[p] < WIN;
    endfunction

    task automatic model_reset();
        for (int p = 0; p < 5; p++) begin
            q1[p] = 0; q2[p] = 0; q3[p] = 0; age[p] = WIN;
        end
        m_mode = 0; m_idle = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        bit fa, ra, pdnpin, fxrise;
        int nm;
        fa = mact(3); ra = mact(4);
        pdnpin = !mact(1) && q2[1];
        fxrise = q2[3] && !q3[3];
        if (m_mode == 0) m_cnt = 0;
        else if (fxrise && m_cnt < 2) m_cnt++;
        if (pdnpin) nm = 0;
        else if (fa && ra) nm = 1;
        else if (fa) nm = 2;
        else if (ra) nm = 3;
        else if (m_idle >= PD - 1) nm = 0;
        else nm = m_mode;
        if (fa || ra) m_idle = 0;
        else if (m_idle != PD) m_idle++;
        m_mode = nm;
        for (int p = 0; p < 5; p++) begin
            if (q2[p] != q3[p]) age[p] = 0;
            else if (age[p] != WIN) age[p]++;
            q3[p] = q2[p]; q2[p] = q1[p]; q1[p] = pin_v[p];
        end
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic compare_model();
        bit sel;
        int ef;
        sel = mact(2) || q2[2];
        ef = alaw ? (sel ? 2 : 1) : (sel ? 1 : 2);
        chk("R3 mode", mode_o, m_mode);
        chk("R4 master clock source", mclk_src_rx_o, int'(m_mode == 3 && mact(1)));
        chk("R5 receive bit clock source", rx_bclk_src_rx_o, int'(mact(2)));
        chk("R6 frequency code", freq_code_o, ef);
        chk("R11 transmit enable", tx_oe_o, int'(m_cnt == 2 && (m_mode == 1 || m_mode == 2)));
        chk("R9 gsx enable", gsx_en_o, int'(m_mode != 0));
        chk("R10 receive ground", rx_gnd_o, int'(m_mode == 0 || m_mode == 2));
        chk("R10 receive data enable", rx_data_en_o, int'(m_mode == 1 || m_mode == 3));
    endtask

    task automatic cycle();
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        #1;
        cyc++;
        for (int p = 0; p < 5; p++)
            if (half[p] != 0 && (cyc % half[p]) == 0) pin_v[p] = !pin_v[p];
        @(negedge clk);
        if (!rst) compare_model();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic set_pin(int p, int hp, bit lvl);
        half[p] = hp;
        if (hp == 0) pin_v[p] = lvl;
    endtask

    initial begin
        for (int p = 0; p < 5; p++) begin pin_v[p] = 0; half[p] = 0; end
        run(4);
        chk("R1 reset mode", mode_o, 0);
        chk("R1 reset tx enable", tx_oe_o, 0);
        chk("R1 reset gsx", gsx_en_o, 0);
        rst = 1'b0;
        run(20);
        chk("R1 idle after reset mode", mode_o, 0);
        chk("R6 mu-law select low", freq_code_o, 2);

        // full duplex
        set_pin(0, 2, 0); set_pin(2, 3, 0); set_pin(3, 5, 0); set_pin(4, 5, 0);
        run(80);
        chk("R3 full duplex", mode_o, 1);
        chk("R11 enabled after two pulses", tx_oe_o, 1);
        chk("R4 transmit master clock", mclk_src_rx_o, 0);
        chk("R5 receive bit clock toggling", rx_bclk_src_rx_o, 1);
        chk("R6 mu-law bit clock toggling", freq_code_o, 1);

        // transmit half channel
        set_pin(4, 0, 0);
        run(30);
        chk("R3 transmit half", mode_o, 2);
        chk("R10 receive grounded", rx_gnd_o, 1);
        chk("R10 receive data ignored", rx_data_en_o, 0);

        // receive half channel
        set_pin(3, 0, 0); set_pin(4, 5, 0); set_pin(1, 2, 0);
        run(30);
        chk("R3 receive half", mode_o, 3);
        chk("R4 receive master clock", mclk_src_rx_o, 1);
        chk("R10 transmit quiet", tx_oe_o, 0);
        chk("R10 input amp on", gsx_en_o, 1);
        set_pin(1, 0, 0);
        run(20);
        chk("R4 fallback to transmit master", mclk_src_rx_o, 0);

        // select levels and law
        set_pin(2, 0, 1);
        run(20);
        chk("R5 static select", rx_bclk_src_rx_o, 0);
        chk("R6 mu-law select high", freq_code_o, 1);
        alaw = 1'b1;
        run(1);
        chk("R6 a-law select high", freq_code_o, 2);
        set_pin(2, 0, 0);
        run(20);
        chk("R6 a-law select low", freq_code_o, 1);

        // activity window
        set_pin(2, 6, 0);
        run(30);
        chk("R2 toggling within window", rx_bclk_src_rx_o, 1);
        set_pin(2, 0, pin_v[2]);
        run(2);
        chk("R2 still active just after stop", rx_bclk_src_rx_o, 1);
        run(WIN + 2);
        chk("R2 static after window", rx_bclk_src_rx_o, 0);

        // forced power-down by strap
        set_pin(1, 0, 1);
        run(WIN + 4);
        chk("R8 strap forces power-down", mode_o, 0);
        chk("R9 gsx off", gsx_en_o, 0);
        chk("R9 receive grounded", rx_gnd_o, 1);
        set_pin(1, 0, 0);
        run(10);
        chk("R8 wake with strap low", mode_o, 3);

        // overlap: strap cycling while transmit sync runs
        set_pin(3, 4, 0);
        run(30);
        set_pin(1, 0, 1);
        run(WIN + 4);
        chk("R8 power-down during full duplex", mode_o, 0);
        set_pin(1, 0, 0);
        for (int i = 0; i < 20 && mode_o == 0; i++) run(1);
        chk("R11 no enable at wake", tx_oe_o, 0);
        run(24);
        chk("R11 enable after second pulse", tx_oe_o, 1);

        // idle timeout
        set_pin(3, 0, 0); set_pin(4, 0, 0);
        run(WIN + PD / 2);
        chk("R7 mode kept during idle", mode_o, 1);
        run(PD / 2 + 10);
        chk("R7 timeout power-down", mode_o, 0);
        chk("R9 tx enable off", tx_oe_o, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(100000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule